// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Manager

This block sits on the controller side of an SDR DRAM and keeps its contents alive. In normal operation an interval timer builds up a count of owed auto-refreshes. The block asks the access arbiter for the command bus, closes all banks with a precharge-all if they might be open, and then issues the owed REF commands one after another. Refreshes that the arbiter delays are remembered up to a parameterized limit and are issued back to back once the grant arrives.

A level request puts the device into self-refresh. The block waits until the read path reports that the last read data has left the data bus. It then issues REF in the same cycle as it drives the clock enable low, and keeps clock enable low until the request falls. On exit it raises clock enable and holds NOP for a setup-plus-recovery window before any other command. Two variants are chosen at elaboration. In the distributed variant, one refresh is owed at the end of the exit window. In the burst variant, a full set of back-to-back refreshes is issued before entry and another full set after exit.

Top module: `dram_refresh_mgr`

## Requirements
- R1: While the bus is granted and the banks are idle, consecutive REF commands (cmd code 2) are exactly REF_INTERVAL cycles apart. The timer is halted during self-refresh and the exit window.
- R2: A REF is preceded by PALL (cmd code 1) unless banks_idle_i is high or this block has precharged the banks since the grant was last held. When PALL is needed, the REF follows it by T_RP+1 cycles.
- R3: bus_req_o is high whenever a refresh is owed, an entry is pending, or the block is in any state other than idle. A non-NOP command (NOP is code 0) appears only in a cycle after one in which bus_gnt_i was high.
- R4: The count of owed refreshes saturates at MAX_POSTPONE. Owed refreshes are issued back to back, T_RFC+1 cycles apart.
- R5: Self-refresh entry is a REF with cke_o low in the same cycle. It happens only after a cycle with rd_idle_i high and no refresh owed.
- R6: Throughout self-refresh, cke_o stays low and cmd_o is NOP after the entry cycle.
- R7: When sr_req_i falls during self-refresh, cke_o rises in the next cycle. cmd_o then stays NOP and state_o reads exit for T_CKE_SU+T_XREF cycles, so the first later command comes no sooner than T_CKE_SU+T_XREF+1 cycles after the rise.
- R8: In the distributed variant (BURST_EN=0), one refresh is owed at the end of the exit window, and it is issued in the first following cycle when the bus is granted and the banks are ready.
- R9: In the burst variant (BURST_EN=1), at least BURST_COUNT REF commands are issued between the rise of sr_req_i and entry, and at least BURST_COUNT more follow the exit window.
- R10: state_o encodes idle 0, precharging 1, refreshing 2, self-refresh 3, exiting 4.
- R11: During and just after reset, cke_o is high, cmd_o is NOP, state_o is idle and bus_req_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_gnt_i | input | 1 | Arbiter grants the command bus to this block |
| banks_idle_i | input | 1 | All banks are known to be precharged |
| rd_idle_i | input | 1 | Last read data has left the data bus |
| sr_req_i | input | 1 | High requests self-refresh; low requests exit |
| bus_req_o | output | 1 | Request for the command bus |
| cmd_o | output | 2 | Command: 0 NOP, 1 precharge-all, 2 refresh |
| cke_o | output | 1 | Clock enable to the device |
| state_o | output | 3 | Current state code (see R10) |

## Verification
The bench runs a distributed and a burst instance side by side on the same stimulus, with a behavioural model of each. First it holds the grant with idle banks; the refresh spacing there shows whether the timer period is right. It then withdraws the grant for many intervals with the banks marked busy. This separates the saturating postponement and the precharge-first path from plain periodic refresh. The self-refresh request is first raised while reads are still in flight, which shows that entry waits for the read-idle signal. It is later dropped, which exposes the exit quiet window and the refresh owed after it.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

   typedef enum logic [1:0] {
      CMD_NOP  = 2'd0,
      CMD_PALL = 2'd1,
      CMD_REF  = 2'd2
   } dram_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PRE  = 3'd1,
      ST_REF  = 3'd2,
      ST_SELF = 3'd3,
      ST_EXIT = 3'd4
   } rfm_state_e;

endpackage

// File: rtl/rfm_interval_timer.sv
module rfm_interval_timer #(
   parameter int unsigned INTERVAL = 243
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   localparam int unsigned W = $clog2(INTERVAL);
   localparam logic [W-1:0] LAST = W'(INTERVAL - 1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!run_i)        cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/rfm_debt_counter.sv
module rfm_debt_counter #(
   parameter int unsigned MAX = 8,
   parameter int unsigned W   = $clog2(MAX + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         dec_i,
   input  logic         seed_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] TOP = W'(MAX);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else if (seed_i) cnt_q <= W'(1);
      else begin
         case ({inc_i, dec_i})
            2'b10:   if (cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
            2'b01:   if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/rfm_wait_counter.sv
module rfm_wait_counter #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic         done_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load_i)       cnt_q <= load_val_i;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);
endmodule

// File: rtl/rfm_burst_tally.sv
module rfm_burst_tally #(
   parameter int unsigned COUNT = 2048,
   parameter int unsigned W     = $clog2(COUNT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic dec_i,
   output logic busy_o
);
   logic [W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    left_q <= '0;
      else if (load_i)               left_q <= W'(COUNT);
      else if (dec_i && left_q != '0) left_q <= left_q - 1'b1;
   end

   assign busy_o = (left_q != '0);
endmodule

// File: rtl/dram_refresh_mgr.sv
module dram_refresh_mgr
   import dram_refresh_pkg::*;
#(
   parameter int unsigned REF_INTERVAL = 243,
   parameter int unsigned MAX_POSTPONE = 8,
   parameter int unsigned T_RP         = 3,
   parameter int unsigned T_RFC        = 9,
   parameter int unsigned T_CKE_SU     = 1,
   parameter int unsigned T_XREF       = 9,
   parameter int unsigned BURST_EN     = 0,
   parameter int unsigned BURST_COUNT  = 2048
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_gnt_i,
   input  logic       banks_idle_i,
   input  logic       rd_idle_i,
   input  logic       sr_req_i,
   output logic       bus_req_o,
   output logic [1:0] cmd_o,
   output logic       cke_o,
   output logic [2:0] state_o
);
   localparam int unsigned T_EXIT   = T_CKE_SU + T_XREF;
   localparam int unsigned WAIT_A   = (T_RP > T_RFC) ? T_RP : T_RFC;
   localparam int unsigned WAIT_MAX = (WAIT_A > T_EXIT) ? WAIT_A : T_EXIT;
   localparam int unsigned WAIT_W   = $clog2(WAIT_MAX + 1);
   localparam int unsigned DEBT_W   = $clog2(MAX_POSTPONE + 1);

   if (REF_INTERVAL < 2) begin : g_bad_interval
      $error("REF_INTERVAL must be at least 2");
   end
   if (MAX_POSTPONE < 1) begin : g_bad_postpone
      $error("MAX_POSTPONE must be at least 1");
   end
   if (T_RP < 1 || T_RFC < 1 || T_XREF < 1) begin : g_bad_timing
      $error("T_RP, T_RFC and T_XREF must be at least 1");
   end
   if (BURST_EN > 1) begin : g_bad_variant
      $error("BURST_EN must be 0 or 1");
   end
   if (BURST_COUNT < 1) begin : g_bad_burst
      $error("BURST_COUNT must be at least 1");
   end

   rfm_state_e        st_q;
   dram_cmd_e         cmd_q;
   logic              cke_q;
   logic              clean_q;
   logic              tick;
   logic              timer_run;
   logic [DEBT_W-1:0] debt_cnt;
   logic              debt_nz;
   logic              burst_busy;
   logic              entry_ok;
   logic              seed_debt;
   logic              work;
   logic              want;
   logic              ready_banks;
   logic              go;
   logic              issue_pall;
   logic              issue_ref;
   logic              issue_entry;
   logic              wait_done;
   logic              exit_start;
   logic              exit_done;
   logic              wait_load;
   logic [WAIT_W-1:0] wait_val;

   // refresh timing and debt
   assign timer_run = (st_q != ST_SELF) && (st_q != ST_EXIT);

   rfm_interval_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (timer_run),
      .tick_o (tick)
   );

   rfm_debt_counter #(.MAX(MAX_POSTPONE), .W(DEBT_W)) u_debt (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_i  (tick),
      .dec_i  (issue_ref && debt_nz),
      .seed_i (seed_debt),
      .cnt_o  (debt_cnt)
   );

   assign debt_nz = (debt_cnt != '0);

   // decision logic
   always_comb begin
      work        = debt_nz || burst_busy;
      want        = work || entry_ok;
      ready_banks = clean_q || banks_idle_i;
      go          = (st_q == ST_IDLE) && bus_gnt_i && want;
      issue_pall  = go && !ready_banks;
      issue_ref   = go && ready_banks && work;
      issue_entry = go && ready_banks && !work;
      bus_req_o   = (st_q == ST_IDLE) ? want : 1'b1;
      exit_start  = (st_q == ST_SELF) && !sr_req_i;
      exit_done   = (st_q == ST_EXIT) && wait_done;
   end

   // variant selection: burst sets around self-refresh or one owed refresh after exit
   if (BURST_EN != 0) begin : g_burst
      logic arm_q;
      logic burst_load;

      assign burst_load = ((st_q == ST_IDLE) && sr_req_i && !arm_q) || exit_done;
      assign entry_ok   = sr_req_i && rd_idle_i && arm_q && !burst_busy;
      assign seed_debt  = 1'b0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            arm_q <= 1'b0;
         else if (!sr_req_i)                    arm_q <= 1'b0;
         else if (issue_entry)                  arm_q <= 1'b0;
         else if ((st_q == ST_IDLE) && !arm_q)  arm_q <= 1'b1;
      end

      rfm_burst_tally #(.COUNT(BURST_COUNT)) u_burst (
         .clk    (clk),
         .rst_n  (rst_n),
         .load_i (burst_load),
         .dec_i  (issue_ref && !debt_nz),
         .busy_o (burst_busy)
      );
   end else begin : g_distributed
      assign burst_busy = 1'b0;
      assign entry_ok   = sr_req_i && rd_idle_i;
      assign seed_debt  = exit_done;
   end

   // phase timing
   always_comb begin
      wait_load = issue_pall || issue_ref || exit_start;
      if (issue_pall)      wait_val = WAIT_W'(T_RP - 1);
      else if (issue_ref)  wait_val = WAIT_W'(T_RFC - 1);
      else                 wait_val = WAIT_W'(T_EXIT - 1);
   end

   rfm_wait_counter #(.W(WAIT_W)) u_wait (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (wait_load),
      .load_val_i (wait_val),
      .done_o     (wait_done)
   );

   // state, command and clock enable registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cmd_q   <= CMD_NOP;
         cke_q   <= 1'b1;
         clean_q <= 1'b0;
      end else begin
         cmd_q <= CMD_NOP;
         cke_q <= !(issue_entry || ((st_q == ST_SELF) && sr_req_i));

         if ((st_q == ST_PRE) && wait_done) clean_q <= 1'b1;
         else if (!bus_gnt_i)               clean_q <= 1'b0;

         case (st_q)
            ST_IDLE: begin
               if (issue_pall) begin
                  cmd_q <= CMD_PALL;
                  st_q  <= ST_PRE;
               end else if (issue_ref) begin
                  cmd_q <= CMD_REF;
                  st_q  <= ST_REF;
               end else if (issue_entry) begin
                  cmd_q <= CMD_REF;
                  st_q  <= ST_SELF;
               end
            end
            ST_PRE, ST_REF, ST_EXIT: begin
               if (wait_done) st_q <= ST_IDLE;
            end
            ST_SELF: begin
               if (exit_start) st_q <= ST_EXIT;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_o   = cmd_q;
   assign cke_o   = cke_q;
   assign state_o = st_q;
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
   parameter int unsigned MAX_POSTPONE = 8,
   parameter int unsigned DEBT_W       = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_gnt_i,
   input logic              rd_idle_i,
   input logic              bus_req_o,
   input logic [1:0]        cmd_o,
   input logic              cke_o,
   input logic [2:0]        state_o,
   input logic [DEBT_W-1:0] debt_i
);
   AST_CMD_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o != 2'd0) |-> $past(bus_gnt_i)); // R3

   AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 3'd0) |-> bus_req_o); // R3

   AST_ENTRY_IS_REF: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke_o) |-> (cmd_o == 2'd2)); // R5

   AST_ENTRY_AFTER_READS: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_o == 2'd2) && !cke_o) |-> $past(rd_idle_i)); // R5

   AST_SELF_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd3) |-> !cke_o); // R6

   AST_SELF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_o == 3'd3) && ($past(state_o) == 3'd3)) |-> (cmd_o == 2'd0)); // R6

   AST_EXIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd4) |-> (cke_o && (cmd_o == 2'd0))); // R7

   AST_PALL_ENTERS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 2'd1) |-> (state_o == 3'd1)); // R2

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      debt_i <= DEBT_W'(MAX_POSTPONE)); // R4
endmodule

bind dram_refresh_mgr dram_refresh_chk #(
   .MAX_POSTPONE (MAX_POSTPONE),
   .DEBT_W       (DEBT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_gnt_i (bus_gnt_i),
   .rd_idle_i (rd_idle_i),
   .bus_req_o (bus_req_o),
   .cmd_o     (cmd_o),
   .cke_o     (cke_o),
   .state_o   (state_o),
   .debt_i    (debt_cnt)
);

// File: tb/dram_refresh_mgr_bench.sv
module rfm_ref_model #(
   parameter int INTV  = 64,
   parameter int MAXP  = 4,
   parameter int TRP   = 2,
   parameter int TRFC  = 4,
   parameter int TEXIT = 4,
   parameter int BURST = 0,
   parameter int BCNT  = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gnt,
   input  logic bidle,
   input  logic rdidle,
   input  logic sr,
   output int   e_cmd,
   output int   e_cke,
   output int   e_st,
   output int   e_req
);
   int tm, debt, bl, arm, clean, wt;
   int work, rdy, eok, go, pall, refc, ent, tick, exd, dec, ld;

   always @* begin
      if (e_st == 0)
         e_req = (debt > 0 || bl > 0 ||
                  (BURST != 0 ? (sr && rdidle && arm != 0 && bl == 0) : (sr && rdidle))) ? 1 : 0;
      else
         e_req = 1;
   end

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tm = 0; debt = 0; bl = 0; arm = 0; clean = 0; wt = 0;
         e_st = 0; e_cmd = 0; e_cke = 1;
      end else begin
         work = (debt > 0 || bl > 0) ? 1 : 0;
         rdy  = (clean != 0 || bidle) ? 1 : 0;
         if (BURST != 0) eok = (sr && rdidle && arm != 0 && bl == 0) ? 1 : 0;
         else            eok = (sr && rdidle) ? 1 : 0;
         go   = (e_st == 0 && gnt && (work != 0 || eok != 0)) ? 1 : 0;
         pall = (go != 0 && rdy == 0) ? 1 : 0;
         refc = (go != 0 && rdy != 0 && work != 0) ? 1 : 0;
         ent  = (go != 0 && rdy != 0 && work == 0) ? 1 : 0;
         tick = (e_st != 3 && e_st != 4 && tm == INTV - 1) ? 1 : 0;
         exd  = (e_st == 4 && wt == 0) ? 1 : 0;
         dec  = (refc != 0 && debt > 0) ? 1 : 0;

         if (e_st == 3 || e_st == 4 || tm == INTV - 1) tm = 0;
         else tm++;

         if (BURST == 0 && exd != 0) debt = 1;
         else if (tick != 0 && dec == 0) begin
            if (debt < MAXP) debt++;
         end else if (dec != 0 && tick == 0) debt--;

         if (BURST != 0) begin
            ld = ((e_st == 0 && sr && arm == 0) || exd != 0) ? 1 : 0;
            if (ld != 0) bl = BCNT;
            else if (refc != 0 && dec == 0 && bl > 0) bl--;
            if (!sr) arm = 0;
            else if (ent != 0) arm = 0;
            else if (e_st == 0 && arm == 0) arm = 1;
         end

         if (e_st == 1 && wt == 0) clean = 1;
         else if (!gnt) clean = 0;

         e_cke = (ent != 0 || (e_st == 3 && sr)) ? 0 : 1;
         e_cmd = 0;
         case (e_st)
            0: begin
               if (pall != 0) begin e_cmd = 1; e_st = 1; wt = TRP - 1; end
               else if (refc != 0) begin e_cmd = 2; e_st = 2; wt = TRFC - 1; end
               else if (ent != 0) begin e_cmd = 2; e_st = 3; end
            end
            3: if (!sr) begin e_st = 4; wt = TEXIT - 1; end
            default: begin
               if (wt == 0) e_st = 0;
               else wt--;
            end
         endcase
      end
   end
endmodule

module dram_refresh_mgr_bench;
   localparam int INTV = 64;
   localparam int MAXP = 4;
   localparam int TRP  = 2;
   localparam int TRFC = 4;
   localparam int TSU  = 1;
   localparam int TXR  = 3;
   localparam int BCNT = 6;
   localparam int TEXIT = TSU + TXR;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gnt = 1'b0, bidle = 1'b1, rdidle = 1'b1, sr = 1'b0;
   logic       req_a, cke_a, req_b, cke_b;
   logic [1:0] cmd_a, cmd_b;
   logic [2:0] st_a, st_b;
   int e_cmd_a, e_cke_a, e_st_a, e_req_a;
   int e_cmd_b, e_cke_b, e_st_b, e_req_b;
   int n_checks = 0, n_err = 0, cyc = 0, b_refs = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc++;

   dram_refresh_mgr #(.REF_INTERVAL(INTV), .MAX_POSTPONE(MAXP), .T_RP(TRP), .T_RFC(TRFC),
      .T_CKE_SU(TSU), .T_XREF(TXR), .BURST_EN(0), .BURST_COUNT(BCNT)) u_dram_refresh_mgr (
      .clk(clk), .rst_n(rst_n), .bus_gnt_i(gnt), .banks_idle_i(bidle), .rd_idle_i(rdidle),
      .sr_req_i(sr), .bus_req_o(req_a), .cmd_o(cmd_a), .cke_o(cke_a), .state_o(st_a));

   dram_refresh_mgr #(.REF_INTERVAL(INTV), .MAX_POSTPONE(MAXP), .T_RP(TRP), .T_RFC(TRFC),
      .T_CKE_SU(TSU), .T_XREF(TXR), .BURST_EN(1), .BURST_COUNT(BCNT)) u_dram_refresh_mgr_burst (
      .clk(clk), .rst_n(rst_n), .bus_gnt_i(gnt), .banks_idle_i(bidle), .rd_idle_i(rdidle),
      .sr_req_i(sr), .bus_req_o(req_b), .cmd_o(cmd_b), .cke_o(cke_b), .state_o(st_b));

   rfm_ref_model #(.INTV(INTV), .MAXP(MAXP), .TRP(TRP), .TRFC(TRFC), .TEXIT(TEXIT),
      .BURST(0), .BCNT(BCNT)) m_dist (
      .clk(clk), .rst_n(rst_n), .gnt(gnt), .bidle(bidle), .rdidle(rdidle), .sr(sr),
      .e_cmd(e_cmd_a), .e_cke(e_cke_a), .e_st(e_st_a), .e_req(e_req_a));

   rfm_ref_model #(.INTV(INTV), .MAXP(MAXP), .TRP(TRP), .TRFC(TRFC), .TEXIT(TEXIT),
      .BURST(1), .BCNT(BCNT)) m_burst (
      .clk(clk), .rst_n(rst_n), .gnt(gnt), .bidle(bidle), .rdidle(rdidle), .sr(sr),
      .e_cmd(e_cmd_b), .e_cke(e_cke_b), .e_st(e_st_b), .e_req(e_req_b));

   task automatic check(input string tag, input int act, input int exp, input string what);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input int st);
      case (st)
         0:       return "R1";
         1:       return "R2";
         2:       return "R4";
         3:       return "R6";
         default: return "R7";
      endcase
   endfunction

   // cycle-by-cycle comparison against the behavioural models
   always @(negedge clk) begin
      if (rst_n) begin
         check(tag_of(e_st_a), int'(cmd_a), e_cmd_a, "dist cmd");
         check(tag_of(e_st_a), int'(cke_a), e_cke_a, "dist cke");
         check("R10", int'(st_a), e_st_a, "dist state");
         check("R3", int'(req_a), e_req_a, "dist bus_req");
         check("R9", int'(cmd_b), e_cmd_b, "burst cmd");
         check("R9", int'(cke_b), e_cke_b, "burst cke");
         check("R10", int'(st_b), e_st_b, "burst state");
         check("R3", int'(req_b), e_req_b, "burst bus_req");
         if (cmd_b == 2'd2 && cke_b) b_refs++;
      end
   end

   task automatic wait_any_a(output int t, output int code);
      t = -1; code = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (cmd_a != 2'd0) begin t = cyc; code = int'(cmd_a); break; end
      end
   endtask

   task automatic wait_ref_a(output int t);
      int code;
      t = -1;
      for (int i = 0; i < 5000; i++) begin
         wait_any_a(t, code);
         if (code == 2) break;
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int t0, t1, t2, tp, code, bad, b_snap, te;
      repeat (3) @(negedge clk);
      check("R11", int'(cke_a), 1, "cke in reset");
      check("R11", int'(cmd_a), 0, "cmd in reset");
      check("R10", int'(st_a), 0, "state in reset");
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R11", int'(req_a), 0, "bus_req after reset");
      check("R11", int'(cke_b), 1, "burst cke after reset");

      // R1: periodic spacing with grant held
      #1 gnt = 1'b1;
      wait_ref_a(t0);
      wait_ref_a(t1);
      wait_ref_a(t2);
      check("R1", t1 - t0, INTV, "refresh spacing");
      check("R1", t2 - t1, INTV, "refresh spacing again");

      // R3 and R4: postponed refreshes while the grant is withheld
      #1 gnt = 1'b0; bidle = 1'b0;
      bad = 0;
      for (int i = 0; i < 6 * INTV; i++) begin
         @(negedge clk);
         if (cmd_a != 2'd0) bad++;
      end
      check("R3", bad, 0, "commands without grant");
      check("R3", int'(req_a), 1, "request while owed");
      #1 gnt = 1'b1;
      wait_any_a(tp, code);
      check("R2", code, 1, "precharge-all before refresh");
      wait_ref_a(t0);
      check("R2", t0 - tp, TRP + 1, "precharge to refresh gap");
      wait_ref_a(t1);
      check("R4", t1 - t0, TRFC + 1, "postponed refresh back to back");
      wait_ref_a(t2);
      check("R4", t2 - t1, TRFC + 1, "postponed refresh back to back");
      #1 bidle = 1'b1;
      repeat (2 * INTV) @(negedge clk);

      // R5: entry waits for read idle
      b_snap = b_refs;
      #1 sr = 1'b1; rdidle = 1'b0;
      bad = 0;
      for (int i = 0; i < 3 * INTV; i++) begin
         @(negedge clk);
         if (!cke_a) bad++;
      end
      check("R5", bad, 0, "entry while reads in flight");
      #1 rdidle = 1'b1;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (!cke_a) break;
      end
      check("R5", int'(cmd_a), 2, "entry command is refresh with cke low");
      check("R10", int'(st_a), 3, "self-refresh state code");
      for (int i = 0; i < 2000; i++) begin
         if (!cke_b) break;
         @(negedge clk);
      end
      check("R9", (b_refs - b_snap >= BCNT) ? 1 : 0, 1, "burst before entry");

      // R6: hold self-refresh
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (cke_a || cmd_a != 2'd0 || st_a != 3'd3) bad++;
      end
      check("R6", bad, 0, "cke low and quiet in self-refresh");

      // R7 and R8: exit window and the refresh owed after it
      b_snap = b_refs;
      #1 sr = 1'b0;
      te = -1;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (cke_a) begin te = cyc; break; end
      end
      check("R7", int'(st_a), 4, "exit state after cke rise");
      wait_any_a(tp, code);
      check("R7", (tp - te >= TEXIT + 1) ? 1 : 0, 1, "quiet window after exit");
      check("R8", tp - te, TEXIT + 1, "refresh right after exit window");
      check("R8", code, 2, "first command after exit is refresh");
      repeat (BCNT * (TRFC + 1) + 10) @(negedge clk);
      check("R9", (b_refs - b_snap >= BCNT) ? 1 : 0, 1, "burst after exit");

      repeat (INTV) @(negedge clk);
      finish_run();
   end
endmodule